// File: doc/BRIEF.md
# FEC Lane Health Monitor

This block sits beside a Reed-Solomon FEC decoder on one physical lane. It takes the decoder's per-codeword verdicts and the marker checker's per-marker verdicts, and turns them into a set of registered lane status bits. The inputs are a codeword strobe with corrected and uncorrected flags plus a symbol-error count, a marker strobe with a good flag, the lane lock indication, an external signal-ok input and a deskew-overflow input.

The block counts symbol errors over a fixed window of codewords and compares the total with a threshold that depends on the code in use. It restarts lane synchronization when a run of bad markers or a run of uncorrectable codewords is seen while the lane is locked. When the error rate first becomes high and bypass indication is enabled, it asserts a sync-header error injection enable for a fixed number of clock cycles. That count defaults to a value inside 60 to 75 ms at 250 MHz.

Top module: `fec_lane_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0, provided `locked` and `sig_ok` are 1.
- R2: One cycle after a strobe on `cw_valid`, `st_uncorr` equals `cw_uncorr`, and `st_corr` equals `cw_corr` and not `cw_uncorr`. Both flags hold until the next codeword. The two flags are never 1 together.
- R3: `st_sig_fail` is 1 exactly one cycle after a cycle in which `sig_ok` is 0 or `dsk_ovf` is 1.
- R4: `st_unlocked` is the inverse of `locked`, delayed by one cycle.
- R5: Codewords are grouped into windows of `WIN_CW` codewords. On the last codeword of a window, `st_hi_ser` is set to 1 if the window's symbol-error total is strictly greater than the threshold, and to 0 otherwise. It holds between window ends. With `code_sel`=0 the threshold is `THR_RS528` (default 417).
- R6: With `code_sel`=1 the threshold is `THR_RS544` (default 6380).
- R7: The symbol-error accumulator saturates at its all-ones value (width clog2(max threshold+1)+1) and never wraps.
- R8: A change of `code_sel` discards the partial window, restarts the window count and clears `st_hi_ser`. A codeword arriving in the cycle of the change is discarded.
- R9: While `locked` is 1, `CW_LIMIT` (3) consecutive uncorrectable codewords set `st_cw_loss` and pulse `restart_sync` for one cycle. A codeword that is not uncorrectable clears both the run and `st_cw_loss`.
- R10: While `locked` is 1, `MK_LIMIT` (5) consecutive markers with `mk_good`=0 set `st_mk_loss` and pulse `restart_sync`. A good marker clears both the run and `st_mk_loss`. While `locked` is 0 the run is held at zero.
- R11: A restart resets both consecutive-bad runs.
- R12: When `st_hi_ser` goes from 0 to 1 and `bypass_en` is 1, `hdr_err_inj` is 1 for exactly `INJ_CYCLES` cycles, starting on the cycle after `st_hi_ser` rises.
- R13: No injection starts when `bypass_en` is 0, or when a window end leaves `st_hi_ser` at 1 without a 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | One decoded codeword result this cycle |
| cw_corr | input | 1 | Codeword had errors that were corrected |
| cw_uncorr | input | 1 | Codeword could not be corrected |
| cw_sym_err | input | SYM_W | Symbol errors counted in this codeword |
| mk_valid | input | 1 | One marker checked this cycle |
| mk_good | input | 1 | Marker was valid |
| locked | input | 1 | Lane is locked to markers or codewords |
| sig_ok | input | 1 | External FEC signal-ok indication |
| dsk_ovf | input | 1 | Deskew buffer overflow |
| code_sel | input | 1 | 0: RS(528) threshold, 1: RS(544) threshold |
| bypass_en | input | 1 | Enable header error injection on high error rate |
| st_uncorr | output | 1 | Last codeword uncorrectable |
| st_corr | output | 1 | Last codeword corrected |
| st_hi_ser | output | 1 | High symbol error rate |
| st_mk_loss | output | 1 | Marker run loss |
| st_cw_loss | output | 1 | Codeword run loss |
| st_unlocked | output | 1 | Lane not locked |
| st_sig_fail | output | 1 | Signal fail |
| restart_sync | output | 1 | One-cycle synchronization restart request |
| hdr_err_inj | output | 1 | Sync-header error injection enable |

## Verification
The assertions check the direct paths on every cycle. They cover the codeword flags following the last codeword and never being set together, signal fail and not-locked tracking their inputs with one cycle of delay, every restart pulse coinciding with a loss flag, and injection starting only after a rise of the error-rate flag with bypass enabled. Window totals against each threshold, accumulator saturation, the window restart on a mode change, the run counters with their clearing by good events and by a restart, and the exact injection length span many cycles. Only the bench's scenarios can show these.

// File: rtl/fec_mon_pkg.sv
package fec_mon_pkg;
  typedef enum logic {
    CODE_RS528 = 1'b0,
    CODE_RS544 = 1'b1
  } code_e;
endpackage

// File: rtl/fec_ser_window.sv
module fec_ser_window #(
  parameter int WIN_CW    = 8192,
  parameter int SYM_W     = 4,
  parameter int THR_RS528 = 417,
  parameter int THR_RS544 = 6380
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cw_valid,
  input  logic [SYM_W-1:0] cw_sym_err,
  input  logic             code_sel,
  output logic             hi_ser,
  output logic             ser_rise
);
  import fec_mon_pkg::*;

  localparam int THR_MAX = (THR_RS528 > THR_RS544) ? THR_RS528 : THR_RS544;
  localparam int ACC_W   = $clog2(THR_MAX + 1) + 1;
  localparam int CNT_W   = (WIN_CW > 1) ? $clog2(WIN_CW) : 1;
  localparam logic [ACC_W:0]   ACC_MAX  = {1'b0, {ACC_W{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CW - 1);

  code_e            mode_q;
  logic [CNT_W-1:0] cw_cnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum_raw;
  logic [ACC_W-1:0] sum_sat;
  logic [ACC_W-1:0] thr;
  logic             over;
  logic             mode_chg;

  assign mode_chg = (code_e'(code_sel) != mode_q);
  assign sum_raw  = {1'b0, acc} + (ACC_W + 1)'(cw_sym_err);
  assign sum_sat  = (sum_raw > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sum_raw[ACC_W-1:0];
  assign thr      = (mode_q == CODE_RS544) ? ACC_W'(THR_RS544) : ACC_W'(THR_RS528);
  assign over     = (sum_sat > thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= CODE_RS528;
      cw_cnt   <= '0;
      acc      <= '0;
      hi_ser   <= 1'b0;
      ser_rise <= 1'b0;
    end else if (mode_chg) begin
      mode_q   <= code_e'(code_sel);
      cw_cnt   <= '0;
      acc      <= '0;
      hi_ser   <= 1'b0;
      ser_rise <= 1'b0;
    end else begin
      ser_rise <= 1'b0;
      if (cw_valid) begin
        if (cw_cnt == CNT_LAST) begin
          hi_ser   <= over;
          ser_rise <= over & ~hi_ser;
          cw_cnt   <= '0;
          acc      <= '0;
        end else begin
          cw_cnt <= cw_cnt + 1'b1;
          acc    <= sum_sat;
        end
      end
    end
  end
endmodule

// File: rtl/fec_bad_run.sv
module fec_bad_run #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ev,
  input  logic bad,
  input  logic clr,
  output logic fire,
  output logic flag
);
  localparam int RUN_W = $clog2(LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LIMIT - 1);

  logic [RUN_W-1:0] run;

  assign fire = en & ev & bad & (run == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      flag <= 1'b0;
    end else if (!en) begin
      run <= '0;
    end else if (ev && bad) begin
      if (fire) begin
        run  <= '0;
        flag <= 1'b1;
      end else if (clr) begin
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else if (ev) begin
      run  <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      run <= '0;
    end
  end
endmodule

// File: rtl/fec_inject_timer.sv
module fec_inject_timer #(
  parameter int INJ_CYCLES = 16_875_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int TW = (INJ_CYCLES > 1) ? $clog2(INJ_CYCLES) : 1;
  localparam logic [TW-1:0] T_LOAD = TW'(INJ_CYCLES - 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      remain <= T_LOAD;
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/fec_lane_monitor.sv
module fec_lane_monitor #(
  parameter int WIN_CW     = 8192,
  parameter int SYM_W      = 4,
  parameter int THR_RS528  = 417,
  parameter int THR_RS544  = 6380,
  parameter int MK_LIMIT   = 5,
  parameter int CW_LIMIT   = 3,
  parameter int INJ_CYCLES = 16_875_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cw_valid,
  input  logic             cw_corr,
  input  logic             cw_uncorr,
  input  logic [SYM_W-1:0] cw_sym_err,
  input  logic             mk_valid,
  input  logic             mk_good,
  input  logic             locked,
  input  logic             sig_ok,
  input  logic             dsk_ovf,
  input  logic             code_sel,
  input  logic             bypass_en,
  output logic             st_uncorr,
  output logic             st_corr,
  output logic             st_hi_ser,
  output logic             st_mk_loss,
  output logic             st_cw_loss,
  output logic             st_unlocked,
  output logic             st_sig_fail,
  output logic             restart_sync,
  output logic             hdr_err_inj
);
  logic mk_fire;
  logic cw_fire;
  logic ser_rise;

  fec_ser_window #(
    .WIN_CW(WIN_CW), .SYM_W(SYM_W), .THR_RS528(THR_RS528), .THR_RS544(THR_RS544)
  ) u_win (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_sym_err(cw_sym_err),
    .code_sel(code_sel), .hi_ser(st_hi_ser), .ser_rise(ser_rise)
  );

  fec_bad_run #(.LIMIT(MK_LIMIT)) u_mk_run (
    .clk(clk), .rst(rst), .en(locked), .ev(mk_valid), .bad(~mk_good),
    .clr(cw_fire), .fire(mk_fire), .flag(st_mk_loss)
  );

  fec_bad_run #(.LIMIT(CW_LIMIT)) u_cw_run (
    .clk(clk), .rst(rst), .en(locked), .ev(cw_valid), .bad(cw_uncorr),
    .clr(mk_fire), .fire(cw_fire), .flag(st_cw_loss)
  );

  fec_inject_timer #(.INJ_CYCLES(INJ_CYCLES)) u_inj (
    .clk(clk), .rst(rst), .start(ser_rise & bypass_en), .active(hdr_err_inj)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_uncorr    <= 1'b0;
      st_corr      <= 1'b0;
      st_unlocked  <= 1'b0;
      st_sig_fail  <= 1'b0;
      restart_sync <= 1'b0;
    end else begin
      if (cw_valid) begin
        st_uncorr <= cw_uncorr;
        st_corr   <= cw_corr & ~cw_uncorr;
      end
      st_unlocked  <= ~locked;
      st_sig_fail  <= ~sig_ok | dsk_ovf;
      restart_sync <= mk_fire | cw_fire;
    end
  end
endmodule

// File: rtl/fec_lane_monitor_chk.sv
module fec_lane_monitor_chk (
  input logic clk,
  input logic rst,
  input logic cw_valid,
  input logic cw_uncorr,
  input logic locked,
  input logic sig_ok,
  input logic dsk_ovf,
  input logic bypass_en,
  input logic st_uncorr,
  input logic st_corr,
  input logic st_hi_ser,
  input logic st_mk_loss,
  input logic st_cw_loss,
  input logic st_unlocked,
  input logic st_sig_fail,
  input logic restart_sync,
  input logic hdr_err_inj
);
  a_r2_uncorr_track: assert property (@(posedge clk) disable iff (rst)
    cw_valid |=> (st_uncorr == $past(cw_uncorr)));

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(st_corr && st_uncorr));

  a_r3_sig_fail: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (st_sig_fail == $past(!sig_ok || dsk_ovf)));

  a_r4_unlocked: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (st_unlocked == $past(!locked)));

  a_r9_restart_cause: assert property (@(posedge clk) disable iff (rst)
    restart_sync |-> (st_mk_loss || st_cw_loss));

  a_r12_inject_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(hdr_err_inj) |-> ($past(st_hi_ser) && $past(bypass_en)));
endmodule

bind fec_lane_monitor fec_lane_monitor_chk u_chk (
  .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_uncorr(cw_uncorr),
  .locked(locked), .sig_ok(sig_ok), .dsk_ovf(dsk_ovf), .bypass_en(bypass_en),
  .st_uncorr(st_uncorr), .st_corr(st_corr), .st_hi_ser(st_hi_ser),
  .st_mk_loss(st_mk_loss), .st_cw_loss(st_cw_loss), .st_unlocked(st_unlocked),
  .st_sig_fail(st_sig_fail), .restart_sync(restart_sync), .hdr_err_inj(hdr_err_inj)
);

// File: tb/fec_lane_monitor_bench.sv
module fec_lane_monitor_bench;
  localparam int WIN  = 16;
  localparam int SYMW = 4;
  localparam int THA  = 10;
  localparam int THB  = 30;
  localparam int INJ  = 20;

  localparam int I_SF = 0, I_UNL = 1, I_CORR = 2, I_UNC = 3, I_CWL = 4,
                 I_MKL = 5, I_HS = 6, I_HDR = 7, I_RS = 8;

  typedef struct {
    int    idx;
    logic  val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cw_valid = 0, cw_corr = 0, cw_uncorr = 0;
  logic [SYMW-1:0] cw_sym_err = '0;
  logic mk_valid = 0, mk_good = 0, locked = 1, sig_ok = 1, dsk_ovf = 0;
  logic code_sel = 0, bypass_en = 0;
  logic st_uncorr, st_corr, st_hi_ser, st_mk_loss, st_cw_loss;
  logic st_unlocked, st_sig_fail, restart_sync, hdr_err_inj;
  logic [8:0] obs;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  fec_lane_monitor #(
    .WIN_CW(WIN), .SYM_W(SYMW), .THR_RS528(THA), .THR_RS544(THB),
    .MK_LIMIT(5), .CW_LIMIT(3), .INJ_CYCLES(INJ)
  ) u_fec_lane_monitor (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_corr(cw_corr),
    .cw_uncorr(cw_uncorr), .cw_sym_err(cw_sym_err), .mk_valid(mk_valid),
    .mk_good(mk_good), .locked(locked), .sig_ok(sig_ok), .dsk_ovf(dsk_ovf),
    .code_sel(code_sel), .bypass_en(bypass_en), .st_uncorr(st_uncorr),
    .st_corr(st_corr), .st_hi_ser(st_hi_ser), .st_mk_loss(st_mk_loss),
    .st_cw_loss(st_cw_loss), .st_unlocked(st_unlocked), .st_sig_fail(st_sig_fail),
    .restart_sync(restart_sync), .hdr_err_inj(hdr_err_inj)
  );

  assign obs = {restart_sync, hdr_err_inj, st_hi_ser, st_mk_loss, st_cw_loss,
                st_uncorr, st_corr, st_unlocked, st_sig_fail};

  function automatic string nm(input int i);
    case (i)
      I_SF: return "st_sig_fail";   I_UNL: return "st_unlocked";
      I_CORR: return "st_corr";     I_UNC: return "st_uncorr";
      I_CWL: return "st_cw_loss";   I_MKL: return "st_mk_loss";
      I_HS: return "st_hi_ser";     I_HDR: return "hdr_err_inj";
      default: return "restart_sync";
    endcase
  endfunction

  // monitor: compare every pending expectation away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (obs[e.idx] !== e.val) begin
        bad++;
        $display("FAIL %s %s: got %0b expected %0b at %0t", e.req, nm(e.idx),
                 obs[e.idx], e.val, $time);
      end
    end
  end

  task automatic expect_bit(input int idx, input logic v, input string req);
    exp_t e;
    e.idx = idx; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic send_cw(input logic c, input logic u, input int s);
    cw_valid = 1'b1; cw_corr = c; cw_uncorr = u; cw_sym_err = SYMW'(s);
    step();
    cw_valid = 1'b0; cw_corr = 1'b0; cw_uncorr = 1'b0; cw_sym_err = '0;
  endtask

  task automatic send_mk(input logic g);
    mk_valid = 1'b1; mk_good = g;
    step();
    mk_valid = 1'b0; mk_good = 1'b0;
  endtask

  // n codewords, the first nerr of them carry s symbol errors
  task automatic send_win(input int nerr, input int s, input int n);
    for (int k = 0; k < n; k++) send_cw(1'b0, 1'b0, (k < nerr) ? s : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    step();
    for (int i = 0; i < 9; i++) expect_bit(i, 1'b0, "R1");
    step();
    rst = 1'b0;
    step();
    for (int i = 0; i < 9; i++) expect_bit(i, 1'b0, "R1");

    // R2: codeword flags
    send_cw(1, 0, 2);
    expect_bit(I_CORR, 1, "R2"); expect_bit(I_UNC, 0, "R2");
    step();
    expect_bit(I_CORR, 1, "R2 hold");
    send_cw(0, 1, 0);
    expect_bit(I_CORR, 0, "R2"); expect_bit(I_UNC, 1, "R2");
    send_cw(1, 1, 0);
    expect_bit(I_CORR, 0, "R2 precedence"); expect_bit(I_UNC, 1, "R2 precedence");
    send_cw(0, 0, 0);
    expect_bit(I_CORR, 0, "R2"); expect_bit(I_UNC, 0, "R2");

    // R3: signal fail
    sig_ok = 0; step(); expect_bit(I_SF, 1, "R3 sig_ok low");
    sig_ok = 1; dsk_ovf = 1; step(); expect_bit(I_SF, 1, "R3 overflow");
    dsk_ovf = 0; step(); expect_bit(I_SF, 0, "R3 clear");

    // R4: not locked
    locked = 0; step(); expect_bit(I_UNL, 1, "R4");
    locked = 1; step(); expect_bit(I_UNL, 0, "R4");

    // R9: codeword run loss
    do_reset();
    send_cw(0, 1, 0); send_cw(0, 1, 0); send_cw(1, 0, 1);
    expect_bit(I_RS, 0, "R9 run broken");
    send_cw(0, 1, 0); send_cw(0, 1, 0);
    expect_bit(I_RS, 0, "R9 two bad"); expect_bit(I_CWL, 0, "R9 two bad");
    send_cw(0, 1, 0);
    expect_bit(I_RS, 1, "R9 third bad"); expect_bit(I_CWL, 1, "R9 third bad");
    step();
    expect_bit(I_RS, 0, "R9 pulse width"); expect_bit(I_CWL, 1, "R9 hold");
    send_cw(0, 1, 0); send_cw(0, 1, 0);
    expect_bit(I_RS, 0, "R11 run reset after restart");
    send_cw(0, 0, 0);
    expect_bit(I_CWL, 0, "R9 clear on good");

    // R10: marker run loss
    do_reset();
    for (int k = 0; k < 4; k++) send_mk(0);
    send_mk(1);
    expect_bit(I_RS, 0, "R10 run broken");
    for (int k = 0; k < 4; k++) send_mk(0);
    expect_bit(I_MKL, 0, "R10 four bad");
    send_mk(0);
    expect_bit(I_RS, 1, "R10 fifth bad"); expect_bit(I_MKL, 1, "R10 fifth bad");
    send_mk(1);
    expect_bit(I_MKL, 0, "R10 clear on good"); expect_bit(I_RS, 0, "R10");
    locked = 0;
    for (int k = 0; k < 6; k++) send_mk(0);
    expect_bit(I_MKL, 0, "R10 unlocked ignored"); expect_bit(I_RS, 0, "R10 unlocked ignored");
    locked = 1;

    // R11: codeword restart clears the marker run
    do_reset();
    for (int k = 0; k < 4; k++) send_mk(0);
    send_cw(0, 1, 0); send_cw(0, 1, 0); send_cw(0, 1, 0);
    expect_bit(I_RS, 1, "R11 cw restart");
    send_mk(0);
    expect_bit(I_MKL, 0, "R11 marker run cleared"); expect_bit(I_RS, 0, "R11");

    // R5: RS528 threshold
    do_reset();
    send_win(1, 10, WIN);
    expect_bit(I_HS, 0, "R5 equal to threshold");
    send_win(1, 11, WIN - 1);
    expect_bit(I_HS, 0, "R5 before window end");
    send_win(0, 0, 1);
    expect_bit(I_HS, 1, "R5 above threshold");
    step();
    expect_bit(I_HDR, 0, "R13 bypass off"); expect_bit(I_HS, 1, "R5 hold");
    send_win(0, 0, WIN);
    expect_bit(I_HS, 0, "R5 clean window");

    // R6: RS544 threshold
    code_sel = 1; step();
    expect_bit(I_HS, 0, "R8");
    send_win(5, 5, WIN);
    expect_bit(I_HS, 0, "R6 25 below 544 threshold");
    send_win(3, 11, WIN);
    expect_bit(I_HS, 1, "R6 33 above 544 threshold");

    // R7: saturation (75 errors, wrap would give 11)
    send_win(0, 0, WIN);
    expect_bit(I_HS, 0, "R7 clean");
    send_win(5, 15, WIN);
    expect_bit(I_HS, 1, "R7 saturated");

    // R8: mode change restarts window
    code_sel = 0;
    do_reset();
    send_win(0, 0, WIN / 2);
    code_sel = 1; step();
    send_win(WIN / 2, 4, WIN / 2);
    expect_bit(I_HS, 0, "R8 window restarted");
    send_win(0, 0, WIN / 2);
    expect_bit(I_HS, 1, "R8 new window end");
    code_sel = 0; step();
    expect_bit(I_HS, 0, "R8 cleared on change");

    // R12 / R13: injection
    do_reset();
    bypass_en = 1;
    send_win(1, 11, WIN);
    expect_bit(I_HS, 1, "R12"); expect_bit(I_HDR, 0, "R12 not yet");
    for (int k = 0; k < INJ; k++) begin
      step();
      expect_bit(I_HDR, 1, "R12 active");
    end
    step();
    expect_bit(I_HDR, 0, "R12 ended");
    send_win(1, 11, WIN);
    expect_bit(I_HS, 1, "R13"); expect_bit(I_HDR, 0, "R13 no retrigger");
    step();
    expect_bit(I_HDR, 0, "R13 no retrigger");
    bypass_en = 0;

    step();
    step();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule